// File: doc/BRIEF.md
# Edge-Placed Pulse Generator

This block produces one rectangular pulse per period from a 16-bit up-counter. The counter starts at zero, runs through a programmable modulus and wraps, so one period lasts modulus plus one counter ticks. The output goes high when the count reaches a rise compare value and goes low when it reaches a fall compare value. Because both edges are placed independently, the rise can be moved later into what would otherwise be the low interval, which gives a delayed-start pulse. A prescaler divides the clock by a power of two before it reaches the counter.

Software writes a new modulus, rise, fall and prescale setting into a shadow set through a small write port. The active set does not change until a load-OK flag is armed, and then only at a period wrap, so a pulse is never cut short or doubled by a change of setting. A run input starts and stops the counter. A force-low input blanks the output at once. A trigger output is high while the count equals the fall value, so a downstream counter sees exactly one event per pulse.

Top module: `edge_pulse_gen`

## Requirements
- R1: After reset, pulseOut, trigOut and ldokOut are all low.
- R2: While runEn is high, the counter starts at 0 in the first running cycle, holds each value for exactly one prescaled tick, and returns to 0 after the tick in which it equals the active modulus. So one period is (modulus+1) ticks.
- R3: The output level goes high when the count becomes equal to the active rise value and low when it becomes equal to the active fall value, and holds in between. If rise equals fall, the fall wins and the output stays low.
- R4: trigOut is high exactly while running with the count equal to the active fall value, so it lasts one prescaled tick per period.
- R5: The prescale field is 3 bits wide with value p. Each counter tick lasts 2^p clock cycles, which covers divide ratios 1 to 128.
- R6: Register writes go only to the shadow set and have no effect on the output until load-OK is used. Address 0 is the modulus, 1 the rise value, 2 the fall value, and 3 the prescale in data bits 2:0.
- R7: When load-OK is armed while running, the shadow set is copied at the next period wrap. The new period starts at count 0 with the new values. ldokOut clears on the same edge.
- R8: When load-OK is armed while stopped, the copy happens on the next clock edge and ldokOut clears.
- R9: While runEn is low, pulseOut and trigOut are low. A later run starts again from count 0.
- R10: forceLow drives pulseOut low in the same cycle. It has no effect on counting or on trigOut.
- R11: With rise greater than fall, the high interval wraps across the period boundary. In the first period after start the output stays low until the count reaches the rise value.
- R12: ldokClr cancels an armed load-OK before the wrap, so no copy takes place and the active pattern continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Shadow register write strobe |
| wrAddr | input | 2 | Shadow register select |
| wrData | input | 16 | Write data |
| runEn | input | 1 | Counter run enable |
| ldokSet | input | 1 | Arm load-OK |
| ldokClr | input | 1 | Cancel load-OK |
| forceLow | input | 1 | Force the pulse output low |
| pulseOut | output | 1 | Pulse output |
| trigOut | output | 1 | Fall-match trigger |
| ldokOut | output | 1 | Load-OK pending flag |

## Verification
The bench targets the moment a new setting takes effect. It arms load-OK in the middle of a period and expects the old pattern up to the exact wrap edge. A design that loaded at once would produce a truncated pulse, and one that loaded a tick late would show a stretched final period. It also writes shadow values with no load-OK and cancels an armed load-OK; a design that leaked shadow values would change the pattern there. Further cases cover the largest divide ratio, where an off-by-one in the prescaler limit stretches or shortens every tick, and rise placed after fall, where a wrong first-period level would give a spurious early pulse. Force-low windows check that blanking does not disturb the counter or the trigger.

// File: rtl/epg_pkg.sv
package epg_pkg;
  typedef struct packed {
    logic tick;     // advance the counter
    logic restart;  // hold counter at its initial value
    logic load;     // copy shadow set to active set
  } epgStrb_t;

  typedef enum logic [1:0] {
    ADDR_MOD  = 2'd0,
    ADDR_RISE = 2'd1,
    ADDR_FALL = 2'd2,
    ADDR_PRSC = 2'd3
  } epgAddr_e;
endpackage

// File: rtl/epg_ctrl.sv
module epg_ctrl
  import epg_pkg::*;
#(
  parameter int PRSC_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              ldokSet,
  input  logic              ldokClr,
  input  logic [PRSC_W-1:0] actPrsc,
  input  logic              atWrap,
  output epgStrb_t          strb,
  output logic              ldokOut
);
  localparam int DIV_W = (1 << PRSC_W) - 1;

  logic [DIV_W-1:0] preCnt;
  logic [DIV_W-1:0] preLim;
  logic             ldokQ;

  assign preLim = ~({DIV_W{1'b1}} << actPrsc);

  always_comb begin
    strb.restart = !runEn;
    strb.tick    = runEn && (preCnt == preLim);
    strb.load    = ldokQ && (!runEn || (strb.tick && atWrap));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (!runEn || strb.tick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldokQ <= 1'b0;
    end else if (ldokClr) begin
      ldokQ <= 1'b0;
    end else if (ldokSet) begin
      ldokQ <= 1'b1;
    end else if (strb.load) begin
      ldokQ <= 1'b0;
    end
  end

  assign ldokOut = ldokQ;

  // R7
  ldok_selfclr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !ldokSet) |=> !ldokQ);

  // R5
  pre_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    runEn |-> (preCnt <= preLim));

  // R12
  ldok_cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldokClr |=> !ldokQ);
endmodule

// File: rtl/epg_datapath.sv
module epg_datapath
  import epg_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRSC_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  epgStrb_t          strb,
  input  logic              runEn,
  input  logic              forceLow,
  output logic [PRSC_W-1:0] actPrsc,
  output logic              atWrap,
  output logic              pulseOut,
  output logic              trigOut
);
  logic [CNT_W-1:0]  shMod, shRise, shFall;
  logic [PRSC_W-1:0] shPrsc;
  logic [CNT_W-1:0]  actMod, actRise, actFall;
  logic [CNT_W-1:0]  cntQ, cntNxt;
  logic [CNT_W-1:0]  useRise, useFall;
  logic              lvlQ;

  function automatic logic edgeEval(input logic [CNT_W-1:0] c,
                                    input logic prev,
                                    input logic [CNT_W-1:0] r,
                                    input logic [CNT_W-1:0] f);
    if (c == f)      return 1'b0;
    else if (c == r) return 1'b1;
    else             return prev;
  endfunction

  // shadow set, written from the register port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shMod  <= '0;
      shRise <= '0;
      shFall <= '0;
      shPrsc <= '0;
    end else if (wrEn) begin
      case (epgAddr_e'(wrAddr))
        ADDR_MOD:  shMod  <= wrData;
        ADDR_RISE: shRise <= wrData;
        ADDR_FALL: shFall <= wrData;
        ADDR_PRSC: shPrsc <= wrData[PRSC_W-1:0];
        default:   ;
      endcase
    end
  end

  // active set, copied on the load strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actMod  <= '0;
      actRise <= '0;
      actFall <= '0;
      actPrsc <= '0;
    end else if (strb.load) begin
      actMod  <= shMod;
      actRise <= shRise;
      actFall <= shFall;
      actPrsc <= shPrsc;
    end
  end

  assign atWrap  = (cntQ == actMod);
  assign cntNxt  = atWrap ? '0 : cntQ + 1'b1;
  assign useRise = strb.load ? shRise : actRise;
  assign useFall = strb.load ? shFall : actFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      lvlQ <= 1'b0;
    end else if (strb.restart) begin
      cntQ <= '0;
      lvlQ <= edgeEval('0, 1'b0, useRise, useFall);
    end else if (strb.tick) begin
      cntQ <= cntNxt;
      lvlQ <= edgeEval(cntNxt, lvlQ, useRise, useFall);
    end
  end

  assign pulseOut = lvlQ && runEn && !forceLow;
  assign trigOut  = runEn && (cntQ == actFall);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= actMod);

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !strb.restart) |=> $stable(cntQ));

  // R9
  stop_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> (!pulseOut && !trigOut));

  // R10
  force_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    forceLow |-> !pulseOut);

  // R6
  act_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(actRise) && $stable(actFall));
endmodule

// File: rtl/edge_pulse_gen.sv
module edge_pulse_gen
  import epg_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRSC_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             runEn,
  input  logic             ldokSet,
  input  logic             ldokClr,
  input  logic             forceLow,
  output logic             pulseOut,
  output logic             trigOut,
  output logic             ldokOut
);
  epgStrb_t          strb;
  logic [PRSC_W-1:0] actPrsc;
  logic              atWrap;

  epg_ctrl #(.PRSC_W(PRSC_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .runEn   (runEn),
    .ldokSet (ldokSet),
    .ldokClr (ldokClr),
    .actPrsc (actPrsc),
    .atWrap  (atWrap),
    .strb    (strb),
    .ldokOut (ldokOut)
  );

  epg_datapath #(.CNT_W(CNT_W), .PRSC_W(PRSC_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .strb     (strb),
    .runEn    (runEn),
    .forceLow (forceLow),
    .actPrsc  (actPrsc),
    .atWrap   (atWrap),
    .pulseOut (pulseOut),
    .trigOut  (trigOut)
  );
endmodule

// File: tb/sim_edge_pulse_gen.sv
`timescale 1ns/1ps
module sim_edge_pulse_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [15:0] wrData = 16'd0;
  logic        runEn = 1'b0;
  logic        ldokSet = 1'b0;
  logic        ldokClr = 1'b0;
  logic        forceLow = 1'b0;
  logic        pulseOut, trigOut, ldokOut;

  int errCnt = 0;
  int chkCnt = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  edge_pulse_gen u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .runEn(runEn), .ldokSet(ldokSet), .ldokClr(ldokClr), .forceLow(forceLow),
    .pulseOut(pulseOut), .trigOut(trigOut), .ldokOut(ldokOut)
  );

  task automatic chk(string req, logic act, logic exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  endtask

  // level implied by the edge rules for count c
  function automatic bit expLvl(int c, int r, int f, bit first);
    if (r == f) return 1'b0;
    if (r < f)  return (c >= r) && (c < f);
    return (c >= r) || (!first && (c < f));
  endfunction

  // j = clock edges since the period base (run start or load wrap)
  task automatic expectAt(int j, int m, int r, int f, int d, bit fl, string req);
    int t, c;
    bit first;
    t = j / d;
    c = t % (m + 1);
    first = ((t / (m + 1)) == 0);
    chk(req, pulseOut, fl ? 1'b0 : expLvl(c, r, f, first));
    chk({req, " trig R4"}, trigOut, (c == f));
  endtask

  task automatic wrReg(int a, int v);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'(a); wrData = 16'(v);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic loadCfg(int m, int r, int f, int p);
    wrReg(0, m); wrReg(1, r); wrReg(2, f); wrReg(3, p);
    ldokSet = 1'b1;
    @(negedge clk);
    ldokSet = 1'b0;
    #1 chk("R8 armed", ldokOut, 1'b1);
    @(negedge clk);
    #1 chk("R8 stopped load clears", ldokOut, 1'b0);
  endtask

  task automatic runSpan(int m, int r, int f, int p, int n, string req);
    @(negedge clk);
    runEn = 1'b1;
    #1 expectAt(0, m, r, f, 1 << p, 1'b0, req);
    for (int j = 1; j <= n; j++) begin
      @(negedge clk);
      #1 expectAt(j, m, r, f, 1 << p, 1'b0, req);
    end
  endtask

  task automatic stopRun();
    @(negedge clk);
    runEn = 1'b0;
    #1 chk("R9 stop output", pulseOut, 1'b0);
    chk("R9 stop trig", trigOut, 1'b0);
    @(negedge clk);
    #1 chk("R9 stopped output", pulseOut, 1'b0);
  endtask

  initial begin
    #(8 * 150000);
    errCnt++; chkCnt++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    int m, r, f, p;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1 chk("R1 pulse", pulseOut, 1'b0);
    chk("R1 trig", trigOut, 1'b0);
    chk("R1 ldok", ldokOut, 1'b0);
    rstN = 1'b1;

    // basic pattern with divide-by-2: period 10 ticks, high on 2..5
    loadCfg(9, 2, 6, 1);
    runSpan(9, 2, 6, 1, 60, "R2 R3 basic");
    stopRun();

    // force-low window; counter and trigger undisturbed
    @(negedge clk);
    runEn = 1'b1;
    #1 expectAt(0, 9, 2, 6, 2, 1'b0, "R10");
    for (int j = 1; j <= 40; j++) begin
      @(negedge clk);
      forceLow = (j >= 10 && j < 24);
      #1 expectAt(j, 9, 2, 6, 2, forceLow, "R10 force");
    end
    forceLow = 1'b0;
    stopRun();

    // shadow writes without load-OK, then a mid-period load-OK, then a cancel
    @(negedge clk);
    runEn = 1'b1;
    #1 expectAt(0, 9, 2, 6, 2, 1'b0, "R6");
    for (int j = 1; j <= 100; j++) begin
      @(negedge clk);
      wrEn = 1'b0; ldokSet = 1'b0; ldokClr = 1'b0;
      if (j >= 1 && j <= 4) begin
        wrEn = 1'b1; wrAddr = 2'(j - 1);
        wrData = (j == 1) ? 16'd4 : (j == 2) ? 16'd1 : (j == 3) ? 16'd3 : 16'd0;
      end
      if (j >= 76 && j <= 79) begin
        wrEn = 1'b1; wrAddr = 2'(j - 76);
        wrData = (j == 76) ? 16'd6 : (j == 77) ? 16'd0 : (j == 78) ? 16'd2 : 16'd2;
      end
      if (j == 41) ldokSet = 1'b1;
      if (j == 80) ldokSet = 1'b1;
      if (j == 81) ldokClr = 1'b1;
      #1;
      if (j < 60) expectAt(j, 9, 2, 6, 2, 1'b0, "R6 no-effect before load");
      else        expectAt(j - 60, 4, 1, 3, 1, 1'b0, "R7 new set after wrap");
      if (j == 30) chk("R6 ldok idle", ldokOut, 1'b0);
      if (j == 42 || j == 59) chk("R7 pending until wrap", ldokOut, 1'b1);
      if (j == 60) chk("R7 cleared at wrap", ldokOut, 1'b0);
      if (j == 82) chk("R12 cancelled", ldokOut, 1'b0);
    end
    wrEn = 1'b0; ldokSet = 1'b0; ldokClr = 1'b0;
    stopRun();

    // rise after fall: wraps across the boundary
    loadCfg(7, 5, 2, 0);
    runSpan(7, 5, 2, 0, 24, "R11 wrap");
    stopRun();

    // largest divide ratio
    loadCfg(1, 0, 1, 7);
    runSpan(1, 0, 1, 7, 520, "R5 div128");
    stopRun();

    // rise equals fall: output stays low
    loadCfg(5, 3, 3, 0);
    runSpan(5, 3, 3, 0, 12, "R3 equal");
    stopRun();

    // randomised settings
    for (int k = 0; k < 10; k++) begin
      m = 2 + int'($urandom % 14);
      p = int'($urandom % 4);
      r = int'($urandom % m);
      f = r + 1 + int'($urandom % (m - r));
      loadCfg(m, r, f, p);
      runSpan(m, r, f, p, 2 * (m + 1) * (1 << p) + 3, "R2 R3 random");
      stopRun();
    end

    finish();
  end
endmodule